// File: doc/BRIEF.md
# Clock-Recovery Lock-Mode Controller

This block is the state machine that decides whether a clock-recovery loop follows its reference clock (reference mode) or the incoming serial data (data mode). Flags from the surrounding circuits tell it whether a valid signal is present, whether the recovered frequency is within the ppm window, and whether the phase is aligned to within a fraction of a unit interval. Another flag reports a loss of data lock. The ppm counter, the phase comparator and the signal detector sit outside the block.

In automatic operation the block starts in reference mode. It enters data mode only after all three qualifications have held together for a set number of consecutive cycles. It falls back to reference mode when data lock is lost. Two override inputs let the system force either mode directly, which cuts lock time when the automatic qualification would be too slow.

The outputs enable either the phase-frequency detector or the data phase detector, never both. A status output reports lock to the reference. A one-cycle strobe marks every change of mode.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `mode_data` is 0, `pfd_en` is 1, `pd_en` is 0 and `mode_chg` is 0.
- R2: With both overrides at 0 and the block in reference mode, it switches to data mode on the clock edge that samples the qualification true for the `QUAL_CYCLES`-th consecutive time. The qualification is (`sig_det` or not `sig_det_en`) and `freq_ok` and `phase_ok`. Any cycle in which the qualification is false restarts the count.
- R3: When `sig_det_en` is 0, `sig_det` has no effect, and the signal condition counts as met.
- R4: With both overrides at 0 and the block in data mode, `data_lost`=1 returns it to reference mode at the next clock edge.
- R5: `force_ref`=1 with `force_data`=0 puts the block in reference mode at the next edge. It stays there however long the qualification holds.
- R6: `force_data`=1 puts the block in data mode at the next edge, whatever `force_ref` and `data_lost` are.
- R7: `pd_en` is 1 exactly when `mode_data` is 1, and `pfd_en` is 1 exactly when `mode_data` is 0.
- R8: `locked_ref` equals (not `mode_data`) and `freq_ok` and `phase_ok`, combinationally from the current inputs. It is 0 in data mode.
- R9: `mode_chg` is 1 for exactly the first cycle in which `mode_data` shows a new value, and 0 otherwise.
- R10: Returning both overrides to 0 leaves the current mode unchanged until an automatic condition (R2 or R4) acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_det | input | 1 | Valid signal level present at the receiver input |
| sig_det_en | input | 1 | Use `sig_det` in the qualification |
| freq_ok | input | 1 | Recovered frequency within the ppm window |
| phase_ok | input | 1 | Phase matched to the reference within tolerance |
| data_lost | input | 1 | Lock to data has been lost |
| force_ref | input | 1 | Override: force reference mode |
| force_data | input | 1 | Override: force data mode (wins over `force_ref`) |
| mode_data | output | 1 | 1 = data mode, 0 = reference mode |
| pfd_en | output | 1 | Phase-frequency detector enable |
| pd_en | output | 1 | Data phase detector enable |
| locked_ref | output | 1 | Locked to the reference clock |
| mode_chg | output | 1 | One-cycle strobe on every mode change |

## Verification
On every cycle, the assertions check that the detector enables are mutually exclusive and that `locked_ref` is never high in data mode. They also check that the strobe matches a change of mode, and that the forced and lost-lock transitions happen at the next edge. They further check that an unqualified cycle never lets the block leave reference mode. Only the bench scenarios can show the exact length of the consecutive-cycle window, the restart of the count after a single broken cycle, and that a disabled signal detector is ignored. The same holds for a mode being kept when the overrides are released.

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det,
  input  logic sig_det_en,
  input  logic freq_ok,
  input  logic phase_ok,
  input  logic data_lost,
  input  logic force_ref,
  input  logic force_data,
  output logic mode_data,
  output logic pfd_en,
  output logic pd_en,
  output logic locked_ref,
  output logic mode_chg
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] qcnt;
  logic             qual, auto_mode, next_mode, counting;

  assign qual      = (sig_det | ~sig_det_en) & freq_ok & phase_ok;
  assign auto_mode = ~force_ref & ~force_data;
  assign counting  = auto_mode & ~mode_data & qual;

  always_comb begin
    next_mode = mode_data;
    if (force_data)      next_mode = 1'b1;
    else if (force_ref)  next_mode = 1'b0;
    else if (mode_data)  next_mode = ~data_lost;
    else if (qual && qcnt == LAST) next_mode = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_data <= 1'b0;
      mode_chg  <= 1'b0;
      qcnt      <= '0;
    end else begin
      mode_data <= next_mode;
      mode_chg  <= next_mode ^ mode_data;
      qcnt      <= (counting && qcnt != LAST) ? qcnt + 1'b1 : '0;
    end
  end

  assign pfd_en     = ~mode_data;
  assign pd_en      = mode_data;
  assign locked_ref = ~mode_data & freq_ok & phase_ok;
endmodule

module cdr_lock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sig_det,
  input logic sig_det_en,
  input logic freq_ok,
  input logic phase_ok,
  input logic data_lost,
  input logic force_ref,
  input logic force_data,
  input logic mode_data,
  input logic pfd_en,
  input logic pd_en,
  input logic locked_ref,
  input logic mode_chg
);
  logic q_ok;
  assign q_ok = (sig_det | ~sig_det_en) & freq_ok & phase_ok;

  a_r7_det_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en != pfd_en) && (pd_en == mode_data));
  a_r8_no_ref_lock_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    locked_ref |-> (!mode_data && freq_ok && phase_ok));
  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg == (mode_data != $past(mode_data)));
  a_r4_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ref && !force_data && mode_data && data_lost) |=> !mode_data);
  a_r5_force_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ref && !force_data) |=> !mode_data);
  a_r6_force_data: assert property (@(posedge clk) disable iff (!rst_n)
    force_data |=> mode_data);
  a_r2_no_unqualified_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_ref && !force_data && !mode_data && !q_ok) |=> !mode_data);
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .sig_det_en(sig_det_en),
  .freq_ok(freq_ok), .phase_ok(phase_ok), .data_lost(data_lost),
  .force_ref(force_ref), .force_data(force_data), .mode_data(mode_data),
  .pfd_en(pfd_en), .pd_en(pd_en), .locked_ref(locked_ref), .mode_chg(mode_chg)
);

// File: tb/cdr_lock_ctrl_test.sv
module cdr_lock_ctrl_test;
  localparam int Q = 4;
  localparam int NV = 23;
  // bits: [8]sde [7]sd [6]freq [5]phase [4]lost [3]fref [2]fdata [1]exp_mode [0]exp_chg
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b111100000, 9'b111100000, 9'b111100000,             // R2 count 1..3
    9'b101100000,                                         // R2 break restarts
    9'b111100000, 9'b111100000, 9'b111100000,
    9'b111100011,                                         // R2 4th -> data, R9
    9'b111100010,
    9'b111110001,                                         // R4 lost -> ref
    9'b001100000, 9'b001100000, 9'b001100000,             // R3 sde=0
    9'b001100011,
    9'b000001001,                                         // R5 forced ref
    9'b111101000, 9'b111101000, 9'b111101000, 9'b111101000, // R5 qual ignored
    9'b000011111,                                         // R6 both forces, lost
    9'b000010110,                                         // R6 lost ignored
    9'b000000010,                                         // R10 release keeps mode
    9'b000010001                                          // R4 again
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig_det = 0, sig_det_en = 0, freq_ok = 0, phase_ok = 0;
  logic data_lost = 0, force_ref = 0, force_data = 0;
  logic mode_data, pfd_en, pd_en, locked_ref, mode_chg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdr_lock_ctrl #(.QUAL_CYCLES(Q)) uut (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .sig_det_en(sig_det_en),
    .freq_ok(freq_ok), .phase_ok(phase_ok), .data_lost(data_lost),
    .force_ref(force_ref), .force_data(force_data), .mode_data(mode_data),
    .pfd_en(pfd_en), .pd_en(pd_en), .locked_ref(locked_ref), .mode_chg(mode_chg)
  );

  task automatic check(string req, logic em, logic ec);
    logic [4:0] act, exp;
    act = {mode_data, pfd_en, pd_en, locked_ref, mode_chg};
    exp = {em, ~em, em, ~em & freq_ok & phase_ok, ec};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {mode,pfd,pd,lockref,chg} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic [8:0] v);
    {sig_det_en, sig_det, freq_ok, phase_ok, data_lost, force_ref, force_data} = v[8:2];
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); check("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); check("R1 after release", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10)", i), VEC[i][1], VEC[i][0]);
    end

    // R3 contrast: detection enabled and no signal -> never leaves reference
    drive(9'b101100000);
    for (int i = 0; i < 3 * Q; i++) @(negedge clk);
    check("R3 sde=1 sd=0 blocks entry", 1'b0, 1'b0);

    // R8: locked_ref follows inputs combinationally in reference mode
    freq_ok = 1; phase_ok = 0; #1; check("R8 phase not ok", 1'b0, 1'b0);

    // R1: reset mid-run from data mode
    drive(9'b000000100);
    @(negedge clk); check("R6 force into data", 1'b1, 1'b1);
    rst_n = 1'b0; #1; check("R1 async reset", 1'b0, 1'b0);
    drive(9'b000000000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1 after second release", 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule